// File: doc/BRIEF.md
# Merging posted write buffer

This block sits between the write side of a bus master arbiter and the write port of an SDRAM controller. It holds up to `DEPTH` line entries. Each entry is one aligned line of `LINE_DW` doublewords, with a valid bit for every byte. A master write is taken in the same cycle it is offered. The write lands in an entry that already holds its line, or it opens a new entry at the tail. Entries go to memory later, one whole line per beat, oldest first. The memory port never stalls a master unless every entry is in use.

Each entry keeps a small set of the masters that wrote into it. While that entry is being written back, a debug output can show this set. Write-back is started in two ways. The first is a fill level that reaches a programmable watermark. The second is a flush request, which empties the buffer and then pulses a done signal. When the buffer is disabled, each doubleword write goes straight to the memory port and is held until memory takes it.

Control is a four-state machine:
- `ST_IDLE`: nothing is presented from the buffer.
- `ST_DRAIN`: the head entry is presented because of the watermark, or because the buffer was disabled while entries remained.
- `ST_FLUSH`: entries are presented until the buffer is empty.
- `ST_DONE`: lasts one cycle and drives the done pulse.

The transitions are:
- IDLE→DONE: a pending flush finds the buffer empty.
- IDLE→FLUSH: a pending flush finds entries.
- IDLE→DRAIN: the count is non-zero and either the count is at or above the watermark or the buffer is disabled.
- DRAIN→IDLE: on every accepted beat.
- FLUSH→DONE: when the last entry is accepted.
- DONE→IDLE: always.

Top module: `wr_merge_buf`

## Requirements
- R1: While `buf_en` is 1 and either a free entry exists or the write's line is held in a mergeable entry, `wr_ready` is 1 in the same cycle as `wr_valid`, whatever `mem_ready` is. This includes the cycle after reset.
- R2: While `buf_en` is 1, memory sees writes only from entries.
  - Each beat is one line: `mem_addr` is line aligned, and byte k of doubleword d sits at byte lane 4d+k of `mem_data`/`mem_be`.
  - Bytes never written read as zero.
  - A presented beat stays stable until `mem_ready`.
  - Entries below the watermark are not written out.
- R3: A write to a line held in an entry merges into that entry and does not allocate a new one. Byte valids are ORed and the newest data wins on overlapping bytes. The entry being presented to memory is excluded, so a write to its line opens a new entry.
- R4: Each entry keeps a 3-bit master set: bit 0 for `wr_src`=0 (CPU), bit 1 for `wr_src`=1 (PCI), bit 2 for `wr_src`=2 (DMA). Each merge ORs in the writer's bit.
- R5: While an entry is presented and `test_en` is 1, `dbg_master` equals that entry's master set. At all other times it is 0, including during a pass-through write.
- R6: When the entry count is non-zero and at or above `wmark`, entries drain until the count falls below `wmark`. Below it, nothing is presented.
- R7: A one-cycle `flush_req` writes out every entry. `flush_done` then pulses for exactly one cycle. A flush of an empty buffer pulses `flush_done` with no memory write.
- R8: Entries are written out in allocation order, whatever merges came later.
- R9: With all entries in use, a write whose line misses is held with `wr_ready` at 0 until an entry drains. The entry count never exceeds `DEPTH`.
- R10: With `buf_en` at 0 and the buffer empty, a write is presented directly with its doubleword in its lane and only its strobes set, and `wr_ready` follows `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_en | input | 1 | Buffering on (1) or pass-through (0) |
| test_en | input | 1 | Shows the master set on `dbg_master` during write-back |
| wmark | input | $clog2(DEPTH+1) | Entry count that starts a drain |
| flush_req | input | 1 | One-cycle request to empty the buffer |
| flush_done | output | 1 | One-cycle pulse after a flush finishes |
| wr_valid | input | 1 | Master write offered |
| wr_ready | output | 1 | Master write taken this cycle |
| wr_src | input | 2 | Writing master: 0 CPU, 1 PCI, 2 DMA |
| wr_addr | input | ADDR_W | Byte address of the doubleword |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte strobes |
| mem_valid | output | 1 | Line write presented to memory |
| mem_ready | input | 1 | Memory takes the presented write |
| mem_addr | output | ADDR_W | Line-aligned address |
| mem_data | output | LINE_DW*32 | Line data |
| mem_be | output | LINE_DW*4 | Line byte strobes |
| dbg_master | output | 3 | Master set of the entry being written back |

## Verification
Wrong internal state shows up at the ports in one of three ways.

A wrong head pointer or a lost merge shows up on the very next memory beat, as a line out of order, wrong data or a wrong master set. A scoreboard catches it when that beat is accepted.

A wrong count shows up within two cycles of the write that should or should not reach the watermark. `mem_valid` rises too early or not at all, or `wr_ready` drops while an entry is free.

A state machine stuck in a drain state shows up as a missing or repeated `flush_done` pulse, or as `dbg_master` going non-zero while nothing is presented.

// File: rtl/wb_pkg.sv
package wb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_FLUSH,
        ST_DONE
    } wb_state_e;

    localparam logic [1:0] SRC_CPU = 2'd0;
    localparam logic [1:0] SRC_PCI = 2'd1;
    localparam logic [1:0] SRC_DMA = 2'd2;

    function automatic logic [2:0] src_onehot(input logic [1:0] s);
        logic [2:0] r;
        r = 3'b000;
        case (s)
            SRC_CPU: r = 3'b001;
            SRC_PCI: r = 3'b010;
            SRC_DMA: r = 3'b100;
            default: r = 3'b000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wb_lookup.sv
module wb_lookup #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 28,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] vld,
    input  logic [TAG_W-1:0] tags [DEPTH],
    input  logic [IDX_W-1:0] head,
    input  logic             lock_head,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);

    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == req_tag)
                          && !(lock_head && (head == IDX_W'(g)));
    end

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match;

    // R3
    uniq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/wb_drain_fsm.sv
module wb_drain_fsm
    import wb_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_en,
    input  logic             flush_req,
    input  logic [CNT_W-1:0] wmark,
    input  logic [CNT_W-1:0] count,
    input  logic             pop,
    input  logic             last_pop,
    output logic             drain,
    output logic             idle,
    output logic             flush_done
);

    wb_state_e state, state_nxt;
    logic      flush_pend;
    logic      take_flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flush_pend <= 1'b0;
        else        flush_pend <= flush_req | (flush_pend & ~take_flush);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (flush_pend)
                    state_nxt = (count == '0) ? ST_DONE : ST_FLUSH;
                else if (count != '0 && (count >= wmark || !buf_en))
                    state_nxt = ST_DRAIN;
            end
            ST_DRAIN: if (pop)      state_nxt = ST_IDLE;
            ST_FLUSH: if (last_pop) state_nxt = ST_DONE;
            ST_DONE:                state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        drain      = 1'b0;
        idle       = 1'b0;
        flush_done = 1'b0;
        take_flush = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle       = 1'b1;
                take_flush = flush_pend;
            end
            ST_DRAIN: drain      = 1'b1;
            ST_FLUSH: drain      = 1'b1;
            ST_DONE:  flush_done = 1'b1;
        endcase
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    // R6
    wmark_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !flush_pend && buf_en && count != '0 && count >= wmark) |=> drain);

endmodule

// File: rtl/wr_merge_buf.sv
module wr_merge_buf
    import wb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DEPTH   = 4,
    parameter int LINE_DW = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         buf_en,
    input  logic                         test_en,
    input  logic [$clog2(DEPTH+1)-1:0]   wmark,
    input  logic                         flush_req,
    output logic                         flush_done,
    input  logic                         wr_valid,
    output logic                         wr_ready,
    input  logic [1:0]                   wr_src,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [31:0]                  wr_data,
    input  logic [3:0]                   wr_be,
    output logic                         mem_valid,
    input  logic                         mem_ready,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [LINE_DW*32-1:0]        mem_data,
    output logic [LINE_DW*4-1:0]         mem_be,
    output logic [2:0]                   dbg_master
);

    localparam int CNT_W      = $clog2(DEPTH + 1);
    localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LINE_BYTES = LINE_DW * 4;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int LOW_W      = $clog2(LINE_BYTES);
    localparam int TAG_W      = ADDR_W - LOW_W;

    logic [TAG_W-1:0]      ent_tag  [DEPTH];
    logic [LINE_BITS-1:0]  ent_data [DEPTH];
    logic [LINE_BYTES-1:0] ent_bv   [DEPTH];
    logic [2:0]            ent_mask [DEPTH];
    logic [DEPTH-1:0]      ent_vld;

    logic [IDX_W-1:0] head, tail, hit_idx;
    logic [CNT_W-1:0] count;
    logic [TAG_W-1:0] wr_tag;
    logic [LOW_W-3:0] wr_dw;
    logic [LINE_BYTES-1:0] lane_be;
    logic [LINE_BITS-1:0]  lane_data, lane_bits;
    logic [2:0] src_bit;
    logic hit, full, bypass, drain, idle;
    logic buf_accept, alloc, merge, pop, last_pop;
    logic unused_low;

    assign wr_tag     = wr_addr[ADDR_W-1:LOW_W];
    assign wr_dw      = wr_addr[LOW_W-1:2];
    assign unused_low = ^wr_addr[1:0];
    assign src_bit    = src_onehot(wr_src);

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        lane_be   = '0;
        lane_data = '0;
        for (int d = 0; d < LINE_DW; d++) begin
            if (wr_dw == (LOW_W-2)'(d)) begin
                lane_be[d*4 +: 4]    = wr_be;
                lane_data[d*32 +: 32] = wr_data & {{8{wr_be[3]}}, {8{wr_be[2]}},
                                                   {8{wr_be[1]}}, {8{wr_be[0]}}};
            end
        end
        for (int b = 0; b < LINE_BYTES; b++) lane_bits[b*8 +: 8] = {8{lane_be[b]}};
    end

    wb_lookup #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup (
        .clk(clk), .rst_n(rst_n), .vld(ent_vld), .tags(ent_tag), .head(head),
        .lock_head(drain), .req_tag(wr_tag), .hit(hit), .hit_idx(hit_idx)
    );

    assign full       = (count == CNT_W'(DEPTH));
    assign bypass     = !buf_en && idle && (count == '0);
    assign buf_accept = buf_en && wr_valid && (hit || !full);
    assign alloc      = buf_accept && !hit;
    assign merge      = buf_accept && hit;
    assign pop        = drain && mem_ready;
    assign last_pop   = pop && (count == CNT_W'(1)) && !alloc;
    assign wr_ready   = buf_en ? (hit || !full) : (bypass && mem_ready);

    wb_drain_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .flush_req(flush_req),
        .wmark(wmark), .count(count), .pop(pop), .last_pop(last_pop),
        .drain(drain), .idle(idle), .flush_done(flush_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head    <= '0;
            tail    <= '0;
            count   <= '0;
            ent_vld <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_tag[i]  <= '0;
                ent_data[i] <= '0;
                ent_bv[i]   <= '0;
                ent_mask[i] <= '0;
            end
        end else begin
            if (alloc) begin
                ent_vld[tail]  <= 1'b1;
                ent_tag[tail]  <= wr_tag;
                ent_data[tail] <= lane_data;
                ent_bv[tail]   <= lane_be;
                ent_mask[tail] <= src_bit;
                tail           <= step(tail);
            end
            if (merge) begin
                ent_data[hit_idx] <= (ent_data[hit_idx] & ~lane_bits) | lane_data;
                ent_bv[hit_idx]   <= ent_bv[hit_idx] | lane_be;
                ent_mask[hit_idx] <= ent_mask[hit_idx] | src_bit;
            end
            if (pop) begin
                ent_vld[head] <= 1'b0;
                head          <= step(head);
            end
            count <= count + CNT_W'(alloc) - CNT_W'(pop);
        end
    end

    always_comb begin
        if (drain) begin
            mem_valid = 1'b1;
            mem_addr  = {ent_tag[head], {LOW_W{1'b0}}};
            mem_data  = ent_data[head];
            mem_be    = ent_bv[head];
        end else begin
            mem_valid = bypass && wr_valid;
            mem_addr  = {wr_tag, {LOW_W{1'b0}}};
            mem_data  = lane_data;
            mem_be    = lane_be;
        end
        dbg_master = (drain && test_en) ? ent_mask[head] : 3'b000;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R5
    dbg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> dbg_master == 3'b000);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_data)));

    // R1
    zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && wr_valid && count < CNT_W'(DEPTH)) |-> wr_ready);

endmodule

// File: tb/test_wr_merge_buf.sv
module test_wr_merge_buf;

    localparam int AW = 32;
    localparam int DEPTH = 4;
    localparam int LDW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_en = 1'b1, test_en = 1'b1, flush_req = 1'b0;
    logic [2:0] wmark = 3'd3;
    logic flush_done, wr_ready, mem_valid;
    logic wr_valid = 1'b0, mem_ready = 1'b0;
    logic [1:0] wr_src = 2'd0;
    logic [31:0] wr_addr = '0, wr_data = '0;
    logic [3:0] wr_be = '0;
    logic [31:0] mem_addr;
    logic [127:0] mem_data;
    logic [15:0] mem_be;
    logic [2:0] dbg_master;

    wr_merge_buf #(.ADDR_W(AW), .DEPTH(DEPTH), .LINE_DW(LDW)) i_wr_merge_buf (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .test_en(test_en), .wmark(wmark),
        .flush_req(flush_req), .flush_done(flush_done), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_src(wr_src), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be), .dbg_master(dbg_master)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [27:0]  tag;
        logic [127:0] data;
        logic [15:0]  be;
        logic [2:0]   mask;
        logic         byp;
    } line_t;

    line_t mdl[$];
    int n_chk = 0, n_bad = 0;
    bit locked = 0, flushing = 0, ended = 0;

    task automatic chk(input bit ok, input string rq, input logic [191:0] act,
                       input logic [191:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic line_t fold(input line_t t, input logic [1:0] src,
                                   input logic [31:0] a, input logic [31:0] d,
                                   input logic [3:0] be);
        line_t r = t;
        for (int k = 0; k < 4; k++) begin
            if (be[k]) begin
                int p;
                p = int'(a[3:2]) * 4 + k;
                r.data[p*8 +: 8] = d[k*8 +: 8];
                r.be[p] = 1'b1;
            end
        end
        if (src != 2'd3) r.mask = r.mask | (3'b001 << src);
        return r;
    endfunction

    task automatic mdl_write(input logic [1:0] src, input logic [31:0] a,
                             input logic [31:0] d, input logic [3:0] be);
        int idx = -1;
        line_t t;
        for (int i = (locked ? 1 : 0); i < mdl.size(); i++)
            if (!mdl[i].byp && mdl[i].tag == a[31:4]) idx = i;
        if (idx < 0) begin
            t = '0;
            t.tag = a[31:4];
        end else t = mdl[idx];
        t = fold(t, src, a, d, be);
        if (idx < 0) mdl.push_back(t);
        else mdl[idx] = t;
        if (mdl.size() >= int'(wmark)) locked = 1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        line_t e;
        logic [2:0] xd;
        if (rst_n && !ended) begin
            if (mem_valid && mem_ready) begin
                if (mdl.size() == 0) chk(0, "R2 unexpected memory write", mem_addr, 0);
                else begin
                    e = mdl.pop_front();
                    xd = (!e.byp && test_en) ? e.mask : 3'b000;
                    chk({mem_addr, mem_data, mem_be, dbg_master} ===
                        {e.tag, 4'b0000, e.data, e.be, xd},
                        e.byp ? "R10 pass-through beat" : "R8 R3 R4 R5 drained line",
                        {mem_addr, mem_data, mem_be, dbg_master},
                        {e.tag, 4'b0000, e.data, e.be, xd});
                    locked = flushing || (mdl.size() >= int'(wmark));
                end
            end else if (!mem_valid) begin
                chk(dbg_master === 3'b000, "R5 debug zero when idle", dbg_master, 0);
            end
        end
    end

    task automatic put(input logic [1:0] src, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] be, input string rq);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_src = src; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        chk(wr_ready === 1'b1, rq, wr_ready, 1);
        @(posedge clk);
        mdl_write(src, a, d, be);
        #1 wr_valid = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic byp_put(input logic [1:0] src, input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] be, input int hold);
        line_t t = '0;
        t.tag = a[31:4];
        t = fold(t, src, a, d, be);
        t.mask = 3'b000;
        t.byp = 1'b1;
        mdl.push_back(t);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_src = src; wr_addr = a; wr_data = d; wr_be = be;
        if (hold > 0) begin
            mem_ready = 1'b0;
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                chk(wr_ready === 1'b0 && mem_valid === 1'b1, "R10 held while memory busy",
                    {wr_ready, mem_valid}, 2'b01);
                @(posedge clk); #1;
            end
            mem_ready = 1'b1;
        end
        @(negedge clk);
        chk(wr_ready === 1'b1 && mem_valid === 1'b1, "R10 ready follows memory",
            {wr_ready, mem_valid}, 2'b11);
        @(posedge clk); #1 wr_valid = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic do_flush(input string rq);
        int w = 0;
        flushing = 1;
        locked = (mdl.size() > 0);
        @(posedge clk); #1 flush_req = 1'b1;
        @(posedge clk); #1 flush_req = 1'b0;
        @(negedge clk);
        while (flush_done !== 1'b1 && w < 60) begin
            @(negedge clk);
            w++;
        end
        chk(flush_done === 1'b1 && mdl.size() == 0, rq, {flush_done, 8'(mdl.size())}, 9'h100);
        @(negedge clk);
        chk(flush_done === 1'b0, "R7 done lasts one cycle", flush_done, 0);
        flushing = 0;
        locked = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_valid === 1'b0 && flush_done === 1'b0 && dbg_master === 3'b000 &&
            wr_ready === 1'b1, "R1 reset state", {mem_valid, flush_done, dbg_master, wr_ready},
            6'b000001);
        @(posedge clk); #1 rst_n = 1'b1;

        // watermark 3, memory busy while filling
        put(2'd0, 32'h0000_1000, 32'h1122_3344, 4'hF, "R1 first write");
        put(2'd1, 32'h0000_1004, 32'hAABB_CCDD, 4'h3, "R3 merge other dword");
        put(2'd0, 32'h0000_1000, 32'h0000_00EE, 4'h1, "R3 collapse overlap");
        put(2'd2, 32'h0000_2048, 32'h5566_7788, 4'hC, "R4 DMA write");
        @(negedge clk);
        chk(mem_valid === 1'b0, "R6 below watermark no drain", mem_valid, 0);
        put(2'd0, 32'h0000_308C, 32'hCAFE_F00D, 4'hF, "R6 reach watermark");
        @(negedge clk);
        chk(mem_valid === 1'b1 && dbg_master === 3'b011, "R5 debug shows set",
            {mem_valid, dbg_master}, 4'b1011);
        put(2'd1, 32'h0000_1008, 32'h9999_0000, 4'hF, "R3 head locked allocates");
        put(2'd0, 32'h0000_204C, 32'h1234_5678, 4'h5, "R1 R3 merge while full");
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_src = 2'd2; wr_addr = 32'h0000_50C0; wr_data = 32'hDEAD_BEEF;
        wr_be = 4'hF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(wr_ready === 1'b0, "R9 stall when full", wr_ready, 0);
        end
        @(posedge clk); #1 wr_valid = 1'b0;
        mem_ready = 1'b1;
        repeat (12) @(negedge clk);
        chk(mem_valid === 1'b0 && mdl.size() == 2, "R6 drain stops below watermark",
            {mem_valid, 8'(mdl.size())}, 9'h002);
        test_en = 1'b0;
        do_flush("R7 flush empties then done");

        // empty flush
        test_en = 1'b1;
        do_flush("R7 empty flush");

        // order: watermark 4, merge into middle entry
        wmark = 3'd4;
        @(posedge clk); #1 mem_ready = 1'b0;
        put(2'd0, 32'h0000_A000, 32'h0101_0101, 4'hF, "R1 order line 0");
        put(2'd1, 32'h0000_B014, 32'h0202_0202, 4'hF, "R1 order line 1");
        put(2'd2, 32'h0000_C028, 32'h0303_0303, 4'h6, "R1 order line 2");
        put(2'd0, 32'h0000_B01C, 32'h0404_0404, 4'h9, "R3 merge middle");
        put(2'd1, 32'h0000_D03C, 32'h0505_0505, 4'hF, "R1 order line 3");
        @(posedge clk); #1 mem_ready = 1'b1;
        repeat (10) @(negedge clk);
        chk(mem_valid === 1'b0 && mdl.size() == 3, "R8 R6 one drained at watermark 4",
            {mem_valid, 8'(mdl.size())}, 9'h003);
        do_flush("R8 flush remaining in order");

        // pass-through
        buf_en = 1'b0;
        byp_put(2'd0, 32'h0000_E008, 32'h7777_8888, 4'hA, 0);
        byp_put(2'd1, 32'h0000_F00C, 32'h1357_9BDF, 4'hF, 2);

        repeat (5) @(negedge clk);
        chk(mdl.size() == 0, "R2 all expected writes seen", mdl.size(), 0);
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule